// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. A target can be left mid-byte after a reset or an aborted transfer, still holding the data line low. When software or reset logic pulses the trigger, the sequencer plays a fixed clearing pattern on the two open-drain lines. The pattern is a start condition, nine clock pulses with the data line left free, a repeated start, and then a stop. This lets any stuck target shift out its pending bit and return to a known state.

Each output is a pull-low enable for an open-drain pad: 1 pulls the line low and 0 lets the external pull-up raise it. The clock high time, clock low time, start/stop setup time and bus-free time are inputs counted in system clock cycles. A value of zero is treated as one cycle. The block holds busy for the whole pattern and for the bus-free gap after the stop. It then gives a single-cycle done pulse.

Top module: `busclr_seq`

## Requirements
- R1: After reset, and whenever busy is low, both pull enables are 0 (lines released), busy is 0 and done is 0.
- R2: A trigger sampled high while idle raises busy on the next clock edge. Busy then stays high without a gap until the pattern and the bus-free gap have finished.
- R3: Each pattern contains exactly two start events (data pull goes 0→1 while the clock pull is 0 in both cycles) and exactly one stop event (data pull goes 1→0 while the clock pull is 0 in both cycles). The stop comes after both starts.
- R4: Each pattern contains exactly nine clock pulses (clock pull goes 0→1). The data pull is 1 only during the two start hold intervals and one cycle at the first clock fall, so it is released for all nine pulses.
- R5: Every clock-released interval between two clock pulses lasts exactly the high time. Every clock pulse lasts exactly the low time, except the first, which lasts one cycle longer.
- R6: Start setup, start hold, repeated-start setup and repeated-start hold (which is also the stop setup) each last the setup time. The total busy length is 4·setup + 1 + 9·(high + low) + busfree cycles.
- R7: After the stop, both lines stay released for exactly the bus-free time with busy still high.
- R8: Done is high for exactly one cycle per pattern: the first cycle in which busy is low again.
- R9: A trigger while busy is ignored. The pattern neither restarts nor lengthens, and only one done pulse appears.
- R10: A programmed time of zero behaves exactly like a time of one cycle.
- R11: The data pull changes while the clock line is released only on the start, repeated-start and stop edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Start the recovery pattern (ignored while busy) |
| t_high_i | input | CNT_W | Clock high time in cycles |
| t_low_i | input | CNT_W | Clock low time in cycles |
| t_setup_i | input | CNT_W | Start/stop setup and start hold time in cycles |
| t_buf_i | input | CNT_W | Bus-free time after the stop in cycles |
| scl_pull_o | output | 1 | Clock line pull-low enable |
| sda_pull_o | output | 1 | Data line pull-low enable |
| busy_o | output | 1 | Pattern in progress |
| done_o | output | 1 | One-cycle pulse when the pattern completes |

## Verification
The bench runs the pattern under several timing sets, including all-ones and all-zeros. An off-by-one in the phase timer would show as high or low intervals one cycle long or short, or as a wrong total length. A wrong pulse counter would give eight or ten clock pulses. If the data line were released in the same cycle the clock falls, or never released, the start/stop event counts and the data-pulled cycle count would be wrong. A re-trigger in mid-pattern checks that the sequence is not restarted: a restart would stretch busy and could give two done pulses. A reset in mid-pattern must release both lines at once.

// File: rtl/busclr_pkg.sv
package busclr_pkg;

    // Phases of the recovery pattern, in the order they are played
    typedef enum logic [3:0] {
        P_IDLE,
        P_START_SU,   // both released, start setup
        P_START_HD,   // data pulled with clock released: start edge
        P_DROP,       // clock falls while data still pulled (one cycle)
        P_LOW,        // clock pulled, data released
        P_HIGH,       // clock released, data released
        P_RS_SU,      // repeated start setup
        P_RS_HD,      // repeated start hold, doubles as stop setup
        P_BUF         // stop done, bus-free gap
    } phase_t;

    typedef struct packed {
        logic scl;
        logic sda;
    } pull_t;

endpackage

// File: rtl/busclr_timer.sv
module busclr_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    // A loaded value N keeps zero_o low for N-1 cycles; 0 acts as 1.
    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (val_i == '0) ? '0 : val_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R5: the count steps down by one when not reloaded
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

    // R10: a zero load leaves the timer already expired
    p_zero_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && val_i == '0) |=> zero_o);

endmodule

// File: rtl/busclr_lines.sv
module busclr_lines
    import busclr_pkg::*;
(
    input  phase_t phase_i,
    output pull_t  pull_o
);

    always_comb begin
        pull_o = '{scl: 1'b0, sda: 1'b0};
        case (phase_i)
            P_START_HD: pull_o = '{scl: 1'b0, sda: 1'b1};
            P_DROP:     pull_o = '{scl: 1'b1, sda: 1'b1};
            P_LOW:      pull_o = '{scl: 1'b1, sda: 1'b0};
            P_RS_HD:    pull_o = '{scl: 1'b0, sda: 1'b1};
            default:    pull_o = '{scl: 1'b0, sda: 1'b0};
        endcase
    end

endmodule

// File: rtl/busclr_seq.sv
module busclr_seq
    import busclr_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int NUM_PULSES = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] t_high_i,
    input  logic [CNT_W-1:0] t_low_i,
    input  logic [CNT_W-1:0] t_setup_i,
    input  logic [CNT_W-1:0] t_buf_i,
    output logic             scl_pull_o,
    output logic             sda_pull_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam int PW = (NUM_PULSES > 1) ? $clog2(NUM_PULSES) : 1;
    localparam logic [PW-1:0] LAST_PULSE = PW'(NUM_PULSES - 1);

    typedef struct packed {
        phase_t        phase;
        logic [PW-1:0] pulses;
        logic          done;
    } seq_t;

    seq_t             st_d, st_q;
    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    pull_t            pull;

    busclr_timer #(.W(CNT_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    busclr_lines i_lines (
        .phase_i (st_q.phase),
        .pull_o  (pull)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;

        if (st_q.phase == P_IDLE) begin
            if (trig_i) begin
                st_d.phase  = P_START_SU;
                st_d.pulses = '0;
                tmr_load    = 1'b1;
                tmr_val     = t_setup_i;
            end
        end else if (tmr_zero) begin
            tmr_load = 1'b1;
            case (st_q.phase)
                P_START_SU: begin st_d.phase = P_START_HD; tmr_val = t_setup_i; end
                P_START_HD: begin st_d.phase = P_DROP;     tmr_val = CNT_W'(1); end
                P_DROP:     begin st_d.phase = P_LOW;      tmr_val = t_low_i;   end
                P_LOW:      begin st_d.phase = P_HIGH;     tmr_val = t_high_i;  end
                P_HIGH: begin
                    if (st_q.pulses == LAST_PULSE) begin
                        st_d.phase  = P_RS_SU;
                        st_d.pulses = '0;
                        tmr_val     = t_setup_i;
                    end else begin
                        st_d.phase  = P_LOW;
                        st_d.pulses = st_q.pulses + PW'(1);
                        tmr_val     = t_low_i;
                    end
                end
                P_RS_SU:    begin st_d.phase = P_RS_HD;    tmr_val = t_setup_i; end
                P_RS_HD:    begin st_d.phase = P_BUF;      tmr_val = t_buf_i;   end
                P_BUF: begin
                    st_d.phase = P_IDLE;
                    st_d.done  = 1'b1;
                    tmr_load   = 1'b0;
                end
                default: begin
                    st_d.phase = P_IDLE;
                    tmr_load   = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: P_IDLE, pulses: '0, done: 1'b0};
        else        st_q <= st_d;
    end

    assign scl_pull_o = pull.scl;
    assign sda_pull_o = pull.sda;
    assign busy_o     = (st_q.phase != P_IDLE);
    assign done_o     = st_q.done;

    // R1: idle leaves both lines released
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scl_pull_o && !sda_pull_o));

    // R4: pulse counter never passes the last pulse
    p_pulse_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulses <= LAST_PULSE);

    // R8: done is a single cycle and marks the end of busy
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R9: once running, the pattern never returns to its first phase
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.phase != P_START_SU) |=> (st_q.phase != P_START_SU));

    // R11: data moves under a released clock only at start/stop edges
    p_sda_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull_o && !$past(scl_pull_o) && (sda_pull_o != $past(sda_pull_o)))
            |-> (st_q.phase inside {P_START_HD, P_RS_HD, P_BUF}));

endmodule

// File: tb/test_busclr_seq.sv
module test_busclr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [15:0] t_high = '0, t_low = '0, t_setup = '0, t_buf = '0;
    logic        scl_pull, sda_pull, busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;   // 250 MHz

    busclr_seq i_busclr_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig),
        .t_high_i   (t_high),
        .t_low_i    (t_low),
        .t_setup_i  (t_setup),
        .t_buf_i    (t_buf),
        .scl_pull_o (scl_pull),
        .sda_pull_o (sda_pull),
        .busy_o     (busy),
        .done_o     (done)
    );

    // rows: high, low, setup, busfree, expected busy cycles
    localparam logic [15:0] VEC [5][5] = '{
        '{16'd3, 16'd4, 16'd2, 16'd5,  16'd77},
        '{16'd1, 16'd1, 16'd1, 16'd1,  16'd24},
        '{16'd0, 16'd0, 16'd0, 16'd0,  16'd24},
        '{16'd6, 16'd2, 16'd3, 16'd2,  16'd87},
        '{16'd2, 16'd9, 16'd5, 16'd10, 16'd130}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic run_seq(input int th, input int tl, input int ts, input int tb,
                           input int exp_total, input int retrig_at);
        int eh = eff(th), el = eff(tl), es = eff(ts);
        int busy_n = 0, pulses = 0, starts = 0, stops = 0, sda_cyc = 0;
        int hi_run = 0, lo_run = 0, hmin = 9999, hmax = 0, lmin = 9999, lmax = 0;
        int buf_n = 0, done_n = 0, done_busy = 0, cyc = 0, first_busy = 0;
        int stop_before_start = 0;
        bit prev_scl = 0, prev_sda = 0, seen_low = 0, after_stop = 0, finished = 0;
        @(negedge clk);
        t_high = 16'(th); t_low = 16'(tl); t_setup = 16'(ts); t_buf = 16'(tb);
        trig = 1'b1;
        while (!finished && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            trig = (cyc == retrig_at);
            if (cyc == 1) first_busy = busy;
            if (busy) busy_n++;
            if (sda_pull) sda_cyc++;
            if (scl_pull && !prev_scl) begin
                pulses++;
                if (seen_low) begin
                    if (hi_run < hmin) hmin = hi_run;
                    if (hi_run > hmax) hmax = hi_run;
                end
                lo_run = 0;
            end
            if (!scl_pull && prev_scl) begin
                seen_low = 1;
                if (lo_run < lmin) lmin = lo_run;
                if (lo_run > lmax) lmax = lo_run;
                hi_run = 0;
            end
            if (scl_pull) lo_run++; else hi_run++;
            if (!scl_pull && !prev_scl && sda_pull && !prev_sda) starts++;
            if (!scl_pull && !prev_scl && !sda_pull && prev_sda) begin
                stops++;
                after_stop = 1;
                if (starts < 2) stop_before_start = 1;
            end
            if (after_stop && busy && !scl_pull && !sda_pull) buf_n++;
            if (done) begin
                done_n++;
                if (busy) done_busy++;
                finished = 1;
            end
            prev_scl = scl_pull;
            prev_sda = sda_pull;
        end
        trig = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (done) done_n++;
            if (busy) busy_n++;
        end
        check(first_busy == 1, "R2 busy after trigger", first_busy, 1);
        check(busy_n == exp_total, "R6/R10 total busy cycles", busy_n, exp_total);
        check(pulses == 9, "R4 clock pulses", pulses, 9);
        check(starts == 2 && !stop_before_start, "R3 start events", starts, 2);
        check(stops == 1, "R3 stop events", stops, 1);
        check(sda_cyc == 2 * es + 1, "R4/R6 data pulled cycles", sda_cyc, 2 * es + 1);
        check(hmin == eh && hmax == eh, "R5 clock high time", hmax, eh);
        check(lmin == el && lmax == el + 1, "R5 clock low time", lmax, el + 1);
        check(buf_n == eff(tb), "R7 bus-free cycles", buf_n, eff(tb));
        check(done_n == 1 && done_busy == 0, "R8/R9 done pulses", done_n, 1);
    endtask

    // Watchdog
    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!scl_pull && !sda_pull, "R1 lines released in reset", {scl_pull, sda_pull}, 0);
        check(!busy && !done, "R1 busy/done low in reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!scl_pull && !sda_pull && !busy, "R1 idle after reset", {scl_pull, sda_pull, busy}, 0);

        // table walk (row 3 uses zeros: R10)
        for (int r = 0; r < 5; r++) begin
            run_seq(int'(VEC[r][0]), int'(VEC[r][1]), int'(VEC[r][2]),
                    int'(VEC[r][3]), int'(VEC[r][4]), -1);
        end

        // R9: re-trigger in the clock train and in the bus-free gap
        run_seq(3, 4, 2, 5, 77, 20);
        run_seq(3, 4, 2, 5, 77, 74);

        // R1: reset in mid-pattern releases lines at once
        @(negedge clk);
        t_high = 16'd3; t_low = 16'd4; t_setup = 16'd2; t_buf = 16'd5;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        repeat (6) @(negedge clk);
        check(busy, "R2 busy mid-pattern", busy, 1);
        rst_n = 1'b0;
        #1;
        check(!scl_pull && !sda_pull && !busy && !done, "R1 reset mid-pattern",
              {scl_pull, sda_pull, busy, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1 stays idle after reset", {busy, done}, 0);

        // after reset a fresh pattern is complete and normal
        run_seq(1, 1, 1, 1, 24, -1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule